// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port Core with Change Interrupt

This core sits behind a two-wire serial follower front end and turns a simple register bus into sixteen general-purpose pins, grouped as two 8-bit ports. For each pin, software sets the following:

- whether the pin is an input or an output;
- the value it drives, and whether it drives push-pull or open-drain;
- whether the value read back is inverted;
- whether a change on the pin is latched until read;
- whether a pull resistor is enabled, and which way it pulls.

Pin inputs pass through a synchroniser. The core then compares each input with the value software last read. Any unmasked input pin whose value differs from that stored value pulls an active-low interrupt request. A per-pin status register shows which pins caused the request.

Reading a port's input register clears that port's condition. The read copies the current pin values into the comparison store and releases any latched changes.

After reset every pin is an input and every pin is masked. A board therefore starts with no spurious interrupt.

Top module: `gpio_port_core`

## Requirements
- R1: After reset the registers read back as follows: configuration, output, interrupt mask and pull select are 0xFF on both ports; polarity, latch enable, pull enable and output mode are 0x00; int_n is 1 and pin_oe is all zero.
- R2: A register's address is kind*2 + port, where port 0 holds pins 7..0 and port 1 holds pins 15..8. The kinds are: 0 input (read-only), 1 output, 2 polarity, 3 configuration (1 = input), 4 latch enable, 5 pull enable, 6 pull select, 7 output mode, 8 interrupt mask (1 = masked) and 9 interrupt status (read-only). A write to a writable register reads back from the next cycle on. Writes to kinds 0 and 9 have no effect.
- R3: A non-latched pin reads in the input register as the pin value XOR its polarity bit. A pin change becomes visible after exactly two rising clock edges.
- R4: int_n is 0 while any pin configured as an input and unmasked differs (after polarity) from its stored comparison value. Masked pins and pins configured as outputs never assert it.
- R5: The status register has a bit set for exactly those input, unmasked pins whose condition is active.
- R6: Reading a port's input register (rd_en with kind 0) loads that port's comparison value with the current pin values and clears that port's latched changes, so its status bits clear. The other port's status is unaffected.
- R7: With latch enable set, a pin that changed keeps its changed value in the input register, and keeps its interrupt condition, until that port's input register is read, even if the pin returns to its earlier value.
- R8: A pin configured as an output (configuration bit 0) in push-pull mode (output mode bit 0) has pin_oe 1 and pin_out equal to its output bit. An input pin never has pin_oe set.
- R9: In open-drain mode (output mode bit 1), an output bit of 0 drives the pin low (pin_oe 1, pin_out 0). An output bit of 1 releases the pin (pin_oe 0). An open-drain pin never drives high.
- R10: pull_en equals the pull-enable register and pull_up equals the pull-select register (1 = pull-up, 0 = pull-down).
- R11: With the default masks in place, no pin activity asserts int_n and status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address: kind in bits 4..1, port in bit 0 |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; qualifies read side effects on the input register |
| rdata | output | 8 | Read data, combinational from addr |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Output enable per pin |
| pull_en | output | 16 | Pull resistor enable per pin |
| pull_up | output | 16 | Pull direction per pin, 1 = up |
| int_n | output | 1 | Active-low interrupt request |

## Verification
Read data is combinational, so the bench samples rdata half a cycle after setting the address, before the edge that applies the read's side effects. A register write takes effect at the next rising edge, and the outputs derived from it (pin_out, pin_oe, pull_en, pull_up, int_n) are valid after that same edge. A pin change needs two rising edges to pass the synchroniser. The input register, status and int_n then follow combinationally. The timing test therefore samples once after one edge, expecting the old value, and once after two edges, expecting the new one. All other checks wait three edges and sample on the falling edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int KIND_W = 4;

   typedef enum logic [KIND_W-1:0] {
      K_INPUT   = 4'd0,
      K_OUTPUT  = 4'd1,
      K_POLAR   = 4'd2,
      K_DIR     = 4'd3,
      K_LATCH   = 4'd4,
      K_PULLEN  = 4'd5,
      K_PULLSEL = 4'd6,
      K_ODMODE  = 4'd7,
      K_MASK    = 4'd8,
      K_STATUS  = 4'd9
   } reg_kind_e;

   function automatic logic kind_writable(reg_kind_e k);
      return (k != K_INPUT) && (k != K_STATUS) && (k <= K_STATUS);
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s > 0) ? s - 1 : 0];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   input  logic [W-1:0] lat_en,
   input  logic         in_read,
   output logic [W-1:0] in_val,
   output logic [W-1:0] cond,
   output logic [W-1:0] flag
);
   logic [W-1:0] cmp_q, hold_q, flag_q;
   logic [W-1:0] chg;

   assign chg = live ^ cmp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         hold_q <= '0;
         flag_q <= '0;
      end else begin
         hold_q <= (flag_q & hold_q) | (~flag_q & live);
         if (in_read) begin
            cmp_q  <= live;
            flag_q <= '0;
         end else begin
            flag_q <= lat_en & (flag_q | chg);
         end
      end
   end

   assign in_val = (flag_q & hold_q) | (~flag_q & live);
   assign cond   = chg | flag_q;
   assign flag   = flag_q;
endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
   parameter int W = 16
) (
   input  logic [W-1:0] out_val,
   input  logic [W-1:0] dir_in,
   input  logic [W-1:0] od_mode,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);
   assign pin_oe  = ~dir_in & (~od_mode | ~out_val);
   assign pin_out = out_val & ~od_mode;
endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
   import gpio_pkg::*;
#(
   parameter int PORTS       = 2,
   parameter int PORT_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int PINS       = PORTS * PORT_W,
   localparam int PSEL_W     = (PORTS > 1) ? $clog2(PORTS) : 1,
   localparam int ADDR_W     = PSEL_W + KIND_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PORT_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic [PORT_W-1:0] rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic [PINS-1:0]   pull_en,
   output logic [PINS-1:0]   pull_up,
   output logic              int_n
);
   generate
      if (PORTS < 2 || (PORTS & (PORTS - 1)) != 0)
         $error("PORTS must be a power of two of at least 2");
      if (SYNC_STAGES < 2)
         $error("SYNC_STAGES must be at least 2");
      if (PORT_W < 1)
         $error("PORT_W must be positive");
   endgenerate

   reg_kind_e          kind;
   logic [PSEL_W-1:0]  psel;
   logic [PINS-1:0]    out_q, pol_q, dir_q, lat_q, pen_q, psel_q, odm_q, mask_q;
   logic [PINS-1:0]    pin_s, live, in_val, cond, lflag, status;
   logic [PORTS-1:0]   in_rd;

   assign kind = reg_kind_e'(addr[ADDR_W-1:PSEL_W]);
   assign psel = addr[PSEL_W-1:0];

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '1;
         pol_q  <= '0;
         dir_q  <= '1;
         lat_q  <= '0;
         pen_q  <= '0;
         psel_q <= '1;
         odm_q  <= '0;
         mask_q <= '1;
      end else if (wr_en && kind_writable(kind)) begin
         case (kind)
            K_OUTPUT:  out_q [psel*PORT_W +: PORT_W] <= wdata;
            K_POLAR:   pol_q [psel*PORT_W +: PORT_W] <= wdata;
            K_DIR:     dir_q [psel*PORT_W +: PORT_W] <= wdata;
            K_LATCH:   lat_q [psel*PORT_W +: PORT_W] <= wdata;
            K_PULLEN:  pen_q [psel*PORT_W +: PORT_W] <= wdata;
            K_PULLSEL: psel_q[psel*PORT_W +: PORT_W] <= wdata;
            K_ODMODE:  odm_q [psel*PORT_W +: PORT_W] <= wdata;
            K_MASK:    mask_q[psel*PORT_W +: PORT_W] <= wdata;
            default: ;
         endcase
      end
   end

   gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   assign live = pin_s ^ pol_q;

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_port
         assign in_rd[p] = rd_en && (kind == K_INPUT) && (psel == PSEL_W'(p));
         gpio_port_slice #(.W(PORT_W)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .live    (live  [p*PORT_W +: PORT_W]),
            .lat_en  (lat_q [p*PORT_W +: PORT_W]),
            .in_read (in_rd[p]),
            .in_val  (in_val[p*PORT_W +: PORT_W]),
            .cond    (cond  [p*PORT_W +: PORT_W]),
            .flag    (lflag [p*PORT_W +: PORT_W])
         );
      end
   endgenerate

   assign status = cond & dir_q & ~mask_q;
   assign int_n  = ~|status;

   gpio_drive #(.W(PINS)) u_drive (
      .out_val(out_q), .dir_in(dir_q), .od_mode(odm_q),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   assign pull_en = pen_q;
   assign pull_up = psel_q;

   // read mux
   always_comb begin
      rdata = '0;
      case (kind)
         K_INPUT:   rdata = in_val[psel*PORT_W +: PORT_W];
         K_OUTPUT:  rdata = out_q [psel*PORT_W +: PORT_W];
         K_POLAR:   rdata = pol_q [psel*PORT_W +: PORT_W];
         K_DIR:     rdata = dir_q [psel*PORT_W +: PORT_W];
         K_LATCH:   rdata = lat_q [psel*PORT_W +: PORT_W];
         K_PULLEN:  rdata = pen_q [psel*PORT_W +: PORT_W];
         K_PULLSEL: rdata = psel_q[psel*PORT_W +: PORT_W];
         K_ODMODE:  rdata = odm_q [psel*PORT_W +: PORT_W];
         K_MASK:    rdata = mask_q[psel*PORT_W +: PORT_W];
         K_STATUS:  rdata = status[psel*PORT_W +: PORT_W];
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_core_chk.sv
module gpio_port_core_chk #(
   parameter int PORTS  = 2,
   parameter int PORT_W = 8,
   localparam int PINS  = PORTS * PORT_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PINS-1:0]  pin_out,
   input logic [PINS-1:0]  pin_oe,
   input logic             int_n,
   input logic [PINS-1:0]  dir_q,
   input logic [PINS-1:0]  odm_q,
   input logic [PINS-1:0]  mask_q,
   input logic [PINS-1:0]  lat_q,
   input logic [PINS-1:0]  lflag,
   input logic [PORTS-1:0] in_rd
);
   // R11: with every pin masked the request stays idle
   p_all_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> int_n);

   // R8: an input pin is never driven
   p_input_undriven_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & dir_q) == '0);

   // R9: an open-drain pin never drives high
   p_od_never_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_out & odm_q) == '0);

   // R7: a latched change survives every cycle without an input read
   p_latch_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_rd == '0) |=> (($past(lflag & lat_q) & ~lflag) == '0));

   generate
      for (genvar p = 0; p < PORTS; p++) begin : g_rd
         // R6: an input read releases that port's latched changes
         p_read_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_rd[p] |=> (lflag[p*PORT_W +: PORT_W] == '0));
      end
   endgenerate
endmodule

bind gpio_port_core gpio_port_core_chk #(.PORTS(PORTS), .PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe), .int_n(int_n),
   .dir_q(dir_q), .odm_q(odm_q), .mask_q(mask_q), .lat_q(lat_q),
   .lflag(lflag), .in_rd(in_rd)
);

// File: tb/tb_gpio_port_core.sv
module tb_gpio_port_core;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 0, rd_en = 0;
   logic [7:0]  rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out, pin_oe, pull_en, pull_up;
   logic        int_n;
   int          n_chk = 0, n_fail = 0, cyc = 0;

   always #2 clk = ~clk;

   gpio_port_core dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up), .int_n(int_n)
   );

   typedef struct packed {
      logic [4:0] a;
      logic [7:0] wd;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VEC [NV] = '{
      '{5'd2,  8'hA5, 8'hA5}, '{5'd3,  8'h3C, 8'h3C}, '{5'd4,  8'h0F, 8'h0F},
      '{5'd5,  8'h00, 8'h00}, '{5'd10, 8'hF0, 8'hF0}, '{5'd13, 8'h55, 8'h55},
      '{5'd14, 8'h81, 8'h81}, '{5'd17, 8'h7E, 8'h7E}, '{5'd0,  8'hFF, 8'h0F},
      '{5'd18, 8'hFF, 8'h00}, '{5'd1,  8'hFF, 8'h00}
   };

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [7:0] d);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(logic [4:0] a, string req, logic [7:0] exp);
      addr = a; rd_en = 1;
      #1 check(req, {8'h00, rdata}, {8'h00, exp});
      @(negedge clk);
      rd_en = 0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      rd(5'd6, "R1 dir p0", 8'hFF);   rd(5'd7, "R1 dir p1", 8'hFF);
      rd(5'd2, "R1 out p0", 8'hFF);   rd(5'd5, "R1 pol p1", 8'h00);
      rd(5'd8, "R1 latch p0", 8'h00); rd(5'd11, "R1 pen p1", 8'h00);
      rd(5'd12, "R1 psel p0", 8'hFF); rd(5'd15, "R1 odm p1", 8'h00);
      rd(5'd16, "R1 mask p0", 8'hFF); rd(5'd17, "R1 mask p1", 8'hFF);
      check("R1 int_n", {15'd0, int_n}, 16'd1);
      check("R1 pin_oe", pin_oe, 16'h0000);

      // R2: vector table, write then read back
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i].a, VEC[i].wd);
         rd(VEC[i].a, "R2 table", VEC[i].exp);
      end

      // R10: pulls follow registers
      check("R10 pull_en", pull_en, 16'h00F0);
      check("R10 pull_up", pull_up, 16'h55FF);

      // R8: push-pull outputs on port 1
      wr(5'd7, 8'h00);
      check("R8 oe p1", pin_oe & 16'hFF00, 16'hFF00);
      check("R8 out p1", pin_out & 16'hFF00, 16'h3C00);
      // R9: open-drain bits 7 and 0 on port 0, out = A5
      wr(5'd6, 8'h00);
      check("R9 oe released", pin_oe & 16'h00FF, 16'h007E);
      check("R9 out", pin_out & 16'h00FF, 16'h0024);
      wr(5'd2, 8'h00);
      check("R9 oe drive low", pin_oe & 16'h00FF, 16'h00FF);
      check("R9 out low", pin_out & 16'h00FF, 16'h0000);
      wr(5'd6, 8'hFF); wr(5'd7, 8'hFF);
      check("R8 inputs undriven", pin_oe, 16'h0000);

      // restore: no polarity, masks on, resync comparison
      wr(5'd4, 8'h00); wr(5'd17, 8'hFF);
      settle();
      rd(5'd0, "R3 resync p0", 8'h00); rd(5'd1, "R3 resync p1", 8'h00);

      // R3: two-edge synchroniser latency with polarity
      wr(5'd5, 8'h80);
      pin_in = 16'h0100;
      @(negedge clk);
      addr = 5'd1; #1 check("R3 one edge", {8'h00, rdata}, 16'h0080);
      @(negedge clk);
      #1 check("R3 two edges", {8'h00, rdata}, 16'h0081);
      wr(5'd5, 8'h00);
      pin_in = 16'h0000;
      settle();
      rd(5'd1, "R3 back", 8'h00);

      // R4/R5: unmask port 1 pins 11..8
      wr(5'd17, 8'hF0);
      pin_in = 16'h1000;            // pin 12, masked
      settle();
      check("R4 masked pin quiet", {15'd0, int_n}, 16'd1);
      pin_in = 16'h1200;            // pin 9, unmasked
      settle();
      check("R4 int asserted", {15'd0, int_n}, 16'd0);
      rd(5'd19, "R5 status p1", 8'h02);
      rd(5'd18, "R5 status p0", 8'h00);
      // R6: port 0 pin 3 also pending, then read port 1
      wr(5'd16, 8'hF7);
      pin_in = 16'h1208;
      settle();
      rd(5'd18, "R5 status p0 pin3", 8'h08);
      rd(5'd1, "R6 input p1", 8'h12);
      rd(5'd19, "R6 status p1 cleared", 8'h00);
      rd(5'd18, "R6 status p0 kept", 8'h08);
      check("R6 int from p0", {15'd0, int_n}, 16'd0);
      rd(5'd0, "R6 input p0", 8'h08);
      check("R6 int cleared", {15'd0, int_n}, 16'd1);
      // R4: output-configured pin 10 does not interrupt
      wr(5'd7, 8'hFB);
      pin_in = 16'h1608;
      settle();
      check("R4 output pin quiet", {15'd0, int_n}, 16'd1);
      wr(5'd7, 8'hFF);
      pin_in = 16'h0000;
      settle();
      rd(5'd1, "R4 resync", 8'h00); rd(5'd0, "R4 resync p0", 8'h00);

      // R7: latched pin 0 on port 0
      wr(5'd8, 8'h01); wr(5'd16, 8'hFE);
      pin_in = 16'h0001;
      settle();
      pin_in = 16'h0000;
      settle();
      check("R7 int held", {15'd0, int_n}, 16'd0);
      rd(5'd18, "R7 status held", 8'h01);
      rd(5'd0, "R7 latched value", 8'h01);
      check("R7 released", {15'd0, int_n}, 16'd1);
      rd(5'd0, "R7 live again", 8'h00);

      // R11: fresh reset, masks default, pins toggling
      do_reset();
      pin_in = 16'hFFFF;
      settle();
      check("R11 int quiet", {15'd0, int_n}, 16'd1);
      rd(5'd18, "R11 status p0", 8'h00);
      rd(5'd19, "R11 status p1", 8'h00);
      // R2: writes to input and status ignored
      wr(5'd19, 8'hFF);
      rd(5'd19, "R2 status ro", 8'h00);
      wr(5'd0, 8'h00);
      rd(5'd0, "R2 input ro", 8'hFF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule